// File: doc/BRIEF.md
# Display Scan Address Mapper

This block sits between a panel frame timing generator and a synchronous frame buffer that holds 132 rows of 160 pixels, 18 bits each. For every pixel position that the timing generator scans, it works out which buffer word to fetch. The fetch address depends on four settings: a start line for vertical scrolling, mirroring of the column order, mirroring of the row order, and an interleaved mode that places the first half of the display rows on even lines and the second half on odd lines. The word that comes back from the buffer is split into three 6-bit sub-pixel values for the column drivers.

The scan position arrives as a row and column pair with a valid strobe. The block issues a registered read enable and address one cycle later. The buffer returns its word on the following cycle, and the sub-pixels leave the block one cycle after that. Each pixel carries two markers: one for the first pixel of a line and one for the first pixel of a frame. The host can use the frame marker to time its buffer writes so that they do not tear the image.

The block takes a new configuration only on the first pixel of a frame, which is scan position row 0, column 0. It applies that configuration to this pixel and holds it for the rest of the frame. This keeps a scroll or remap change from tearing the picture partway down the panel.

Top module: `scan_addr_mapper`

## Requirements
- R1: When scan_valid is high, rd_en is high on the next cycle with rd_addr = ram_row * 160 + ram_col. When scan_valid is low, rd_en is low on the next cycle.
- R2: ram_row = (line + start) mod 132, for every start value from 0 to 255. Here line is the scan row after interleaving (R4) and row mirroring (R5).
- R3: With column mirroring on, ram_col = 159 - scan_col. With it off, ram_col = scan_col.
- R4: With interleaving on, a scan row d below 66 gives line 2d, and a row d of 66 or more gives line 2(d - 66) + 1. With interleaving off, line = d.
- R5: With row mirroring on, the line from R4 is replaced by 131 - line. This happens before the start offset is added.
- R6: The configuration inputs are sampled only on a valid scan of row 0, column 0, and that pixel already uses the new values. Changes to the configuration inputs at any other time do not change rd_addr.
- R7: pix_valid is high exactly two cycles after rd_en. pix_a, pix_b and pix_c carry bits 17:12, 11:6 and 5:0 of the word that the buffer returned one cycle after that rd_en.
- R8: row_start is high with the pixel from scan column 0. frame_sync is high with the pixel from scan row 0, column 0.
- R9: While rst is high, rd_en, pix_valid, row_start and frame_sync are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_valid | input | 1 | Scan position valid |
| scan_row | input | 8 | Display row being scanned, 0..131 |
| scan_col | input | 8 | Display column being scanned, 0..159 |
| cfg_start_line | input | 8 | Vertical scroll start line |
| cfg_col_mirror | input | 1 | Reverse the column fetch order |
| cfg_com_mirror | input | 1 | Reverse the row order |
| cfg_split | input | 1 | Interleave rows onto even and then odd lines |
| rd_en | output | 1 | Frame buffer read enable |
| rd_addr | output | 15 | Frame buffer word address |
| rd_data | input | 18 | Frame buffer read word, one cycle after rd_en |
| pix_valid | output | 1 | Sub-pixel outputs valid |
| pix_a | output | 6 | Sub-pixel A |
| pix_b | output | 6 | Sub-pixel B |
| pix_c | output | 6 | Sub-pixel C |
| row_start | output | 1 | Pixel is the first of a line |
| frame_sync | output | 1 | Pixel is the first of a frame |

## Verification
The assertions assume three things. The timing generator never presents a valid row at or above 132 or a valid column at or above 160. The buffer answers every read with a fixed one-cycle latency. Interleaving needs an even row count. The stimulus draws rows and columns only inside those bounds and uses a buffer model with that fixed latency. It changes the configuration inputs on almost every cycle, so most of those changes must be ignored, and it crosses every mode combination with start lines at and around the 132 wrap point and at the 8-bit maximum.

// File: rtl/scan_map_pkg.sv
package scan_map_pkg;
  localparam int LINE_W = 8;

  typedef struct packed {
    logic [LINE_W-1:0] start_line;
    logic              col_mirror;
    logic              com_mirror;
    logic              split;
  } scan_cfg_t;
endpackage

// File: rtl/scan_row_map.sv
module scan_row_map #(
  parameter int NUM_ROWS = 132,
  parameter int ROW_W    = 8,
  parameter int LINE_W   = 8
) (
  input  logic [ROW_W-1:0]  disp_row,
  input  logic [LINE_W-1:0] start_line,
  input  logic              split_en,
  input  logic              mirror_en,
  output logic [ROW_W-1:0]  ram_row
);
  localparam int SUM_W = ((ROW_W > LINE_W) ? ROW_W : LINE_W) + 1;
  localparam logic [ROW_W-1:0] HALF   = ROW_W'(NUM_ROWS / 2);
  localparam logic [ROW_W-1:0] LAST   = ROW_W'(NUM_ROWS - 1);
  localparam logic [SUM_W-1:0] ROWS_S = SUM_W'(NUM_ROWS);

  logic [ROW_W-1:0] upper;
  logic [ROW_W-1:0] lin;
  logic [ROW_W-1:0] com;
  logic [SUM_W-1:0] start_s;
  logic [SUM_W-1:0] start_m;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;

  always_comb begin
    // interleave: first half onto even lines, second half onto odd lines
    upper = disp_row - HALF;
    if (!split_en)
      lin = disp_row;
    else if (disp_row < HALF)
      lin = ROW_W'({disp_row, 1'b0});
    else
      lin = ROW_W'({upper, 1'b1});
    // mirror after the interleave
    com = mirror_en ? (LAST - lin) : lin;
    // modulo by conditional subtraction, no divider
    start_s = SUM_W'(start_line);
    start_m = (start_s >= ROWS_S) ? (start_s - ROWS_S) : start_s;
    sum     = SUM_W'(com) + start_m;
    wrapped = (sum >= ROWS_S) ? (sum - ROWS_S) : sum;
    ram_row = ROW_W'(wrapped);
  end
endmodule

// File: rtl/scan_col_map.sv
module scan_col_map #(
  parameter int NUM_COLS = 160,
  parameter int COL_W    = 8
) (
  input  logic [COL_W-1:0] disp_col,
  input  logic             mirror_en,
  output logic [COL_W-1:0] ram_col
);
  localparam logic [COL_W-1:0] LAST = COL_W'(NUM_COLS - 1);

  always_comb begin
    ram_col = mirror_en ? (LAST - disp_col) : disp_col;
  end
endmodule

// File: rtl/subpixel_split.sv
module subpixel_split #(
  parameter int NUM_SUB = 3,
  parameter int SUB_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_line,
  input  logic                     in_frame,
  input  logic [NUM_SUB*SUB_W-1:0] in_word,
  output logic                     out_valid,
  output logic                     out_line,
  output logic                     out_frame,
  output logic [SUB_W-1:0]         out_sub [NUM_SUB]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_line  <= 1'b0;
      out_frame <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_line  <= in_valid & in_line;
      out_frame <= in_valid & in_frame;
    end
  end

  // sub-pixel 0 takes the most significant field
  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    always_ff @(posedge clk) begin
      if (rst)
        out_sub[g] <= '0;
      else if (in_valid)
        out_sub[g] <= in_word[(NUM_SUB-1-g)*SUB_W +: SUB_W];
    end
  end

  // R8
  frm_implies_row_chk: assert property (@(posedge clk) disable iff (rst)
    out_frame |-> (out_line && out_valid));
endmodule

// File: rtl/scan_addr_mapper.sv
module scan_addr_mapper
  import scan_map_pkg::*;
#(
  parameter int NUM_ROWS = 132,
  parameter int NUM_COLS = 160,
  parameter int SUB_W    = 6,
  parameter int NUM_SUB  = 3,
  parameter int ROW_W    = $clog2(NUM_ROWS),
  parameter int COL_W    = $clog2(NUM_COLS),
  parameter int ADDR_W   = $clog2(NUM_ROWS * NUM_COLS),
  parameter int PIX_W    = NUM_SUB * SUB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_valid,
  input  logic [ROW_W-1:0]  scan_row,
  input  logic [COL_W-1:0]  scan_col,
  input  logic [LINE_W-1:0] cfg_start_line,
  input  logic              cfg_col_mirror,
  input  logic              cfg_com_mirror,
  input  logic              cfg_split,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [PIX_W-1:0]  rd_data,
  output logic              pix_valid,
  output logic [SUB_W-1:0]  pix_a,
  output logic [SUB_W-1:0]  pix_b,
  output logic [SUB_W-1:0]  pix_c,
  output logic              row_start,
  output logic              frame_sync
);
  localparam logic [ADDR_W-1:0] COLS_A  = ADDR_W'(NUM_COLS);
  localparam logic [ADDR_W-1:0] TOTAL_A = ADDR_W'(NUM_ROWS * NUM_COLS);
  localparam logic [ROW_W-1:0]  ROWS_R  = ROW_W'(NUM_ROWS);
  localparam logic [COL_W-1:0]  COLS_C  = COL_W'(NUM_COLS);

  scan_cfg_t       cfg_in;
  scan_cfg_t       cfg_q;
  scan_cfg_t       cfg_eff;
  logic            frame_begin;
  logic [ROW_W-1:0] ram_row;
  logic [COL_W-1:0] ram_col;

  logic            line1_q, frame1_q;
  logic            valid2_q, line2_q, frame2_q;
  logic [SUB_W-1:0] sub [NUM_SUB];

  // configuration commits on the first pixel of a frame, which already uses it
  always_comb begin
    cfg_in.start_line = cfg_start_line;
    cfg_in.col_mirror = cfg_col_mirror;
    cfg_in.com_mirror = cfg_com_mirror;
    cfg_in.split      = cfg_split;
    frame_begin = scan_valid && (scan_row == '0) && (scan_col == '0);
    cfg_eff     = frame_begin ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (frame_begin)
      cfg_q <= cfg_in;
  end

  scan_row_map #(
    .NUM_ROWS (NUM_ROWS),
    .ROW_W    (ROW_W),
    .LINE_W   (LINE_W)
  ) i_row_map (
    .disp_row   (scan_row),
    .start_line (cfg_eff.start_line),
    .split_en   (cfg_eff.split),
    .mirror_en  (cfg_eff.com_mirror),
    .ram_row    (ram_row)
  );

  scan_col_map #(
    .NUM_COLS (NUM_COLS),
    .COL_W    (COL_W)
  ) i_col_map (
    .disp_col  (scan_col),
    .mirror_en (cfg_eff.col_mirror),
    .ram_col   (ram_col)
  );

  // stage 1: registered read request
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      line1_q  <= 1'b0;
      frame1_q <= 1'b0;
    end else begin
      rd_en    <= scan_valid;
      line1_q  <= scan_valid && (scan_col == '0);
      frame1_q <= frame_begin;
      if (scan_valid)
        rd_addr <= ADDR_W'(ram_row) * COLS_A + ADDR_W'(ram_col);
    end
  end

  // stage 2: tags aligned with the returning buffer word
  always_ff @(posedge clk) begin
    if (rst) begin
      valid2_q <= 1'b0;
      line2_q  <= 1'b0;
      frame2_q <= 1'b0;
    end else begin
      valid2_q <= rd_en;
      line2_q  <= line1_q;
      frame2_q <= frame1_q;
    end
  end

  subpixel_split #(
    .NUM_SUB (NUM_SUB),
    .SUB_W   (SUB_W)
  ) i_split (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (valid2_q),
    .in_line   (line2_q),
    .in_frame  (frame2_q),
    .in_word   (rd_data),
    .out_valid (pix_valid),
    .out_line  (row_start),
    .out_frame (frame_sync),
    .out_sub   (sub)
  );

  assign pix_a = sub[0];
  assign pix_b = sub[1];
  assign pix_c = sub[2];

  // R1
  scan_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    scan_valid |-> ((scan_row < ROWS_R) && (scan_col < COLS_C)));

  // R1
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr < TOTAL_A));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_begin |=> $stable(cfg_q));

  // R7
  pix_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(rd_en, 2));
endmodule

// File: tb/test_scan_addr_mapper.sv
module test_scan_addr_mapper;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        scan_valid = 1'b0;
  logic [7:0]  scan_row = '0, scan_col = '0, cfg_start_line = '0;
  logic        cfg_col_mirror = 1'b0, cfg_com_mirror = 1'b0, cfg_split = 1'b0;
  logic        rd_en, pix_valid, row_start, frame_sync;
  logic [14:0] rd_addr;
  logic [17:0] rd_data = '0;
  logic [5:0]  pix_a, pix_b, pix_c;

  scan_addr_mapper i_scan_addr_mapper (
    .clk(clk), .rst(rst), .scan_valid(scan_valid), .scan_row(scan_row),
    .scan_col(scan_col), .cfg_start_line(cfg_start_line),
    .cfg_col_mirror(cfg_col_mirror), .cfg_com_mirror(cfg_com_mirror),
    .cfg_split(cfg_split), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pix_valid(pix_valid), .pix_a(pix_a), .pix_b(pix_b), .pix_c(pix_c),
    .row_start(row_start), .frame_sync(frame_sync)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int exp_q[$];
  int pend_q[$];
  bit ren_d1 = 1'b0, ren_d2 = 1'b0;
  int m_start = 0;
  bit m_cm = 1'b0, m_rm = 1'b0, m_sp = 1'b0;

  function automatic logic [17:0] ram_fn(int addr);
    logic [31:0] h;
    h = addr * 32'h9E3779B1 + 32'h1234567;
    return h[29:12];
  endfunction

  function automatic int exp_row(int d, int st, bit sp, bit mr);
    int l;
    l = d;
    if (sp) l = (d < 66) ? 2 * d : 2 * (d - 66) + 1;
    if (mr) l = 131 - l;
    return (l + st) % 132;
  endfunction

  task automatic check(string req, int got, int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  // one-cycle buffer model
  always @(posedge clk) if (rd_en) rd_data <= ram_fn(int'(rd_addr));

  always @(negedge clk) begin
    if (!rst && !done) begin
      // R7 timing of pix_valid against rd_en
      check("R7 pix_valid two cycles after rd_en", int'(pix_valid), int'(ren_d2));
      if (pix_valid) begin
        if (pend_q.size() == 0) check("R7 unexpected pixel", 1, 0);
        else begin
          int rec;
          logic [17:0] w;
          rec = pend_q.pop_front();
          w = ram_fn(rec & 32'hFFFFF);
          check("R7 sub-pixel A", int'(pix_a), int'(w[17:12]));
          check("R7 sub-pixel B", int'(pix_b), int'(w[11:6]));
          check("R7 sub-pixel C", int'(pix_c), int'(w[5:0]));
          check("R8 row_start", int'(row_start), (rec >> 20) & 1);
          check("R8 frame_sync", int'(frame_sync), (rec >> 21) & 1);
        end
      end
      if (rd_en) begin
        if (exp_q.size() == 0) check("R1 unexpected read", 1, 0);
        else begin
          int rec;
          rec = exp_q.pop_front();
          check("R1 R2 R3 R4 R5 R6 read address", int'(rd_addr), rec & 32'hFFFFF);
          pend_q.push_back(rec);
        end
      end
      ren_d2 = ren_d1;
      ren_d1 = rd_en;
    end
  end

  task automatic drive(bit v, int r, int c, int st, bit cm, bit rm, bit sp);
    scan_valid     = v;
    scan_row       = 8'(r);
    scan_col       = 8'(c);
    cfg_start_line = 8'(st);
    cfg_col_mirror = cm;
    cfg_com_mirror = rm;
    cfg_split      = sp;
    if (v) begin
      int a;
      if (r == 0 && c == 0) begin
        m_start = st; m_cm = cm; m_rm = rm; m_sp = sp;
      end
      a = exp_row(r, m_start, m_sp, m_rm) * 160 + (m_cm ? 159 - c : c);
      exp_q.push_back(a | ((c == 0) ? (1 << 20) : 0) | ((r == 0 && c == 0) ? (1 << 21) : 0));
    end
    @(negedge clk);
  endtask

  task automatic drive_rand_cfg(bit v, int r, int c);
    drive(v, r, c, int'($urandom_range(255)), 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    int starts[7] = '{0, 1, 66, 131, 132, 200, 255};
    int rows[6]   = '{0, 1, 65, 66, 130, 131};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9
    check("R9 rd_en in reset", int'(rd_en), 0);
    check("R9 pix_valid in reset", int'(pix_valid), 0);
    check("R9 row_start in reset", int'(row_start), 0);
    check("R9 frame_sync in reset", int'(frame_sync), 0);
    rst = 1'b0;
    // directed: every mode with start lines around the wrap; R6 via garbage cfg mid-frame
    foreach (starts[s]) begin
      for (int m = 0; m < 8; m++) begin
        drive(1'b1, 0, 0, starts[s], m[0], m[1], m[2]);
        foreach (rows[k]) begin
          drive_rand_cfg(1'b1, rows[k], 0);
          drive_rand_cfg(1'b1, rows[k], 159);
        end
        drive_rand_cfg(1'b0, 0, 0);
      end
    end
    // random: mostly mid-frame pixels, occasional frame starts, cfg changing each cycle
    for (int i = 0; i < 20000; i++) begin
      int p;
      p = int'($urandom_range(99));
      if (p < 3) drive_rand_cfg(1'b1, 0, 0);
      else if (p < 20) drive_rand_cfg(1'b0, int'($urandom_range(131)), int'($urandom_range(159)));
      else drive_rand_cfg(1'b1, int'($urandom_range(131)), int'($urandom_range(159)));
    end
    repeat (6) drive_rand_cfg(1'b0, 0, 0);
    check("R1 every scan produced a read", exp_q.size(), 0);
    check("R7 every read produced a pixel", pend_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule